// File: doc/BRIEF.md
# Guarded Routine Loader

This block loads one of several built-in routines from a read-only image store into a window of RAM. Software uses four byte registers on a small write bus: an unlock key, a one-hot routine select, a request bit and a RAM start address. It unlocks the block with a magic key, picks exactly one routine, sets the start address and then sets the request bit. That single write begins the load. No other write is needed.

The sequencer first checks the routine select and the target address. When both are good, it reads the routine image byte by byte from the image port and writes it into RAM just after the start address. In every case it finishes by writing a result byte at the start address. It then clears the select and request registers. While the load runs, the block reports busy and ignores every register write. Interrupt requests that arrive in that time are held back, and each one is passed on once the block is idle again.

Top module: `dlreq_ctrl`

## Requirements
- R1: After reset, all four registers read 0, `busy` is 0, `irq_out` is 0 and no RAM write happens. Register addresses: 0 = key, 1 = select (bit 0 = program routine, image index 0; bit 1 = erase routine, image index 1), 2 = control (bit 0 = request), 3 = RAM start address.
- R2: A write of 1 to the request bit is accepted only while the key register holds 8'hA5. With any other key value, the request bit stays 0 and `busy` stays 0.
- R3: An accepted request write raises `busy` on the next clock with no further write. When the checks pass, image byte `idx*16+i` (i = 0..15) is written to RAM address `start+1+i`. The image port has one cycle of read latency.
- R4: A load with no error writes the result byte 8'h00 at the start address.
- R5: If no routine or more than one routine is selected, result bit 0 is set and no image byte is written.
- R6: If the start address is below 8'h20 or above 8'hCF, result bit 1 is set and no image byte is written. When both errors occur, the result byte is 8'h03.
- R7: When a load completes, the select register and the request bit read 0. The key and start-address registers keep their values.
- R8: `busy` stays high from the clock after acceptance up to and including the cycle of the result-byte write. That is 34 cycles for a successful load and 2 cycles for a rejected one.
- R9: Register writes made while `busy` is high have no effect. This includes a second request.
- R10: While `busy` is high, `irq_out` is 0. A request on `irq_in` during a load shows on `irq_out` for one cycle in the first idle cycle. While the block is idle, `irq_in` passes straight through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| rom_addr | output | 5 | Image store read address |
| rom_rdata | input | 8 | Image store data, one cycle after the address |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 8 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| irq_in | input | 1 | Incoming interrupt request |
| irq_out | output | 1 | Interrupt request passed on to the CPU |
| busy | output | 1 | Load in progress |

## Verification
The bench covers these cases:

- **Key check.** A request written under a wrong key must not start a load. A design that checks the wrong key value would start loads under a wrong key.
- **Select and address errors.** The bench tries an empty select, a double select, start addresses on both edges of the window, and starts just outside it. A design with an off-by-one window test, or one that treats an empty select as valid, would write image bytes where none are allowed or return the wrong result code.
- **Writes during a load.** Register writes during a load, including a second request, must leave no trace. A design that fails here would redirect the copy or restart it.
- **Interrupts during a load.** An interrupt pulse during a load must appear exactly once after the load ends. A design that fails here would either drop the pulse or let it through while busy.

// File: rtl/dlreq_pkg.sv
package dlreq_pkg;
  localparam logic [1:0] REG_KEY  = 2'd0;
  localparam logic [1:0] REG_SEL  = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_DEST = 2'd3;

  localparam logic [7:0] KEY_MAGIC = 8'hA5;

  localparam int RES_SEL_BIT  = 0;
  localparam int RES_ADDR_BIT = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_STORE,
    ST_RESULT
  } cp_state_e;
endpackage

// File: rtl/dlreq_regs.sv
module dlreq_regs
  import dlreq_pkg::*;
#(
  parameter int N_ROUT = 2,
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  input  logic              done,
  output logic [N_ROUT-1:0] sel_q,
  output logic [RAM_AW-1:0] dest_q,
  output logic              start,
  output logic [7:0]        rdata
);
  logic [7:0]        key_q, key_d;
  logic [N_ROUT-1:0] sel_d;
  logic [RAM_AW-1:0] dest_d;
  logic              req_q, req_d;
  logic              wr_ok;

  assign wr_ok = wr_en && !busy;
  assign start = wr_ok && (addr == REG_CTRL) && wdata[0] && (key_q == KEY_MAGIC);

  always_comb begin
    key_d  = key_q;
    sel_d  = sel_q;
    dest_d = dest_q;
    req_d  = req_q;
    if (wr_ok && addr == REG_KEY)  key_d  = wdata;
    if (wr_ok && addr == REG_SEL)  sel_d  = wdata[N_ROUT-1:0];
    if (wr_ok && addr == REG_DEST) dest_d = wdata[RAM_AW-1:0];
    if (start) req_d = 1'b1;
    if (done) begin
      sel_d = '0;
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      sel_q  <= '0;
      dest_q <= '0;
      req_q  <= 1'b0;
    end else begin
      key_q  <= key_d;
      sel_q  <= sel_d;
      dest_q <= dest_d;
      req_q  <= req_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      REG_KEY:  rdata = key_q;
      REG_SEL:  rdata[N_ROUT-1:0] = sel_q;
      REG_CTRL: rdata[0] = req_q;
      default:  rdata[RAM_AW-1:0] = dest_q;
    endcase
  end

  // R2
  req_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> ($past(key_q) == KEY_MAGIC));

  // R9
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(key_q) && $stable(dest_q) && $stable(sel_q)));

  // R7
  clear_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (sel_q == '0 && !req_q));
endmodule

// File: rtl/dlreq_copy_fsm.sv
module dlreq_copy_fsm
  import dlreq_pkg::*;
#(
  parameter int N_ROUT   = 2,
  parameter int IMG_LEN  = 16,
  parameter int RAM_AW   = 8,
  parameter int ROM_AW   = 5,
  parameter int WIN_BASE = 32,
  parameter int WIN_TOP  = 223
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N_ROUT-1:0] sel,
  input  logic [RAM_AW-1:0] dest,
  output logic              busy,
  output logic              done,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_rdata,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata
);
  localparam int CNT_W    = (IMG_LEN > 1) ? $clog2(IMG_LEN) : 1;
  localparam int ROUT_W   = (N_ROUT > 1) ? $clog2(N_ROUT) : 1;
  localparam int MAX_DEST = WIN_TOP - IMG_LEN;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(IMG_LEN - 1);
  localparam logic [ROM_AW-1:0] LEN_W    = ROM_AW'(IMG_LEN);

  cp_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ROUT_W-1:0] idx_q, idx_d, idx_sel;
  logic [7:0]        res_q, res_d;
  int                n_sel;
  logic              sel_err, addr_err;

  always_comb begin
    n_sel   = 0;
    idx_sel = '0;
    for (int i = 0; i < N_ROUT; i++) begin
      if (sel[i]) begin
        n_sel   = n_sel + 1;
        idx_sel = ROUT_W'(i);
      end
    end
  end

  assign sel_err  = (n_sel != 1);
  assign addr_err = (int'(dest) < WIN_BASE) || (int'(dest) > MAX_DEST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    res_d   = res_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_CHECK;
      ST_CHECK: begin
        res_d = '0;
        res_d[RES_SEL_BIT]  = sel_err;
        res_d[RES_ADDR_BIT] = addr_err;
        idx_d = idx_sel;
        cnt_d = '0;
        state_d = (sel_err || addr_err) ? ST_RESULT : ST_FETCH;
      end
      ST_FETCH: state_d = ST_STORE;
      ST_STORE: begin
        if (cnt_q == CNT_LAST) begin
          state_d = ST_RESULT;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          state_d = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      res_q   <= res_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_RESULT);
  assign rom_addr = ROM_AW'(idx_q) * LEN_W + ROM_AW'(cnt_q);

  always_comb begin
    ram_we    = 1'b0;
    ram_addr  = dest;
    ram_wdata = '0;
    if (state_q == ST_STORE) begin
      ram_we    = 1'b1;
      ram_addr  = dest + RAM_AW'(1) + RAM_AW'(cnt_q);
      ram_wdata = rom_rdata;
    end else if (state_q == ST_RESULT) begin
      ram_we    = 1'b1;
      ram_wdata = res_q;
    end
  end

  // R5 R6
  store_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && state_q == ST_STORE) |->
      ($countones(sel) == 1 && int'(dest) >= WIN_BASE && int'(dest) <= MAX_DEST));

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(ram_we) && $past(ram_addr) == dest));
endmodule

// File: rtl/dlreq_irq_hold.sv
module dlreq_irq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic irq_in,
  output logic irq_out
);
  logic hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (busy && irq_in) hold_d = 1'b1;
    else if (!busy)     hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign irq_out = !busy && (irq_in || hold_q);

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq_out);

  // R10
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(irq_in)) |-> irq_out);
endmodule

// File: rtl/dlreq_ctrl.sv
module dlreq_ctrl #(
  parameter int N_ROUT   = 2,
  parameter int IMG_LEN  = 16,
  parameter int RAM_AW   = 8,
  parameter int ROM_AW   = $clog2(N_ROUT * IMG_LEN),
  parameter int WIN_BASE = 32,
  parameter int WIN_TOP  = 223
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [1:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_rdata,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic              irq_in,
  output logic              irq_out,
  output logic              busy
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [N_ROUT-1:0] sel;
  logic [RAM_AW-1:0] dest;
  logic              start;
  logic              done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  dlreq_regs #(.N_ROUT(N_ROUT), .RAM_AW(RAM_AW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_en  (bus_wr_en),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .busy   (busy),
    .done   (done),
    .sel_q  (sel),
    .dest_q (dest),
    .start  (start),
    .rdata  (bus_rdata)
  );

  dlreq_copy_fsm #(
    .N_ROUT(N_ROUT), .IMG_LEN(IMG_LEN), .RAM_AW(RAM_AW),
    .ROM_AW(ROM_AW), .WIN_BASE(WIN_BASE), .WIN_TOP(WIN_TOP)
  ) u_copy (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (start),
    .sel       (sel),
    .dest      (dest),
    .busy      (busy),
    .done      (done),
    .rom_addr  (rom_addr),
    .rom_rdata (rom_rdata),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
  );

  dlreq_irq_hold u_irq (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .busy    (busy),
    .irq_in  (irq_in),
    .irq_out (irq_out)
  );
endmodule

// File: tb/dlreq_ctrl_tb.sv
module dlreq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr_en;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [4:0] rom_addr;
  logic [7:0] rom_rdata;
  logic       ram_we;
  logic [7:0] ram_addr;
  logic [7:0] ram_wdata;
  logic       irq_in;
  logic       irq_out;
  logic       busy;

  int n_cmp = 0;
  int n_bad = 0;
  int nwr = 0;
  int cyc_all = 0;
  logic clr_mem = 1'b0;
  logic [7:0] mem [0:255];

  always #10 clk = ~clk;

  dlreq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rom_addr(rom_addr),
    .rom_rdata(rom_rdata), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .irq_in(irq_in), .irq_out(irq_out), .busy(busy)
  );

  function automatic logic [7:0] img(input int a);
    return 8'((a * 7) + 8'h3C);
  endfunction

  always @(posedge clk) rom_rdata <= img(int'(rom_addr));

  always @(posedge clk) begin
    if (clr_mem) for (int k = 0; k < 256; k++) mem[k] = 8'hEE;
    if (ram_we) begin
      mem[ram_addr] = ram_wdata;
      nwr++;
    end
  end

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc_all);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string rq, input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic clear_ram();
    @(negedge clk); clr_mem = 1'b1;
    @(negedge clk); clr_mem = 1'b0;
  endtask

  task automatic wait_idle(output int bcyc);
    bcyc = 0;
    while (busy && bcyc < 1000) begin
      bcyc++;
      @(negedge clk);
    end
  endtask

  // key, sel, dest, accepted, expected result byte
  localparam int NV = 11;
  localparam logic [26:0] VEC [NV] = '{
    {8'hA5, 2'b01, 8'h40, 1'b1, 8'h00},
    {8'hA5, 2'b10, 8'h80, 1'b1, 8'h00},
    {8'hA5, 2'b11, 8'h40, 1'b1, 8'h01},
    {8'hA5, 2'b00, 8'h40, 1'b1, 8'h01},
    {8'hA5, 2'b01, 8'h10, 1'b1, 8'h02},
    {8'hA5, 2'b01, 8'hD0, 1'b1, 8'h02},
    {8'hA5, 2'b01, 8'hCF, 1'b1, 8'h00},
    {8'hA5, 2'b10, 8'h20, 1'b1, 8'h00},
    {8'hA5, 2'b11, 8'hF0, 1'b1, 8'h03},
    {8'h5A, 2'b01, 8'h40, 1'b0, 8'h00},
    {8'h00, 2'b10, 8'h60, 1'b0, 8'h00}
  };

  initial begin
    int v, bc, w0, bad_img;
    logic [7:0] k, d, er;
    logic [1:0] s;
    logic acc;
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0; irq_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1", v, 0, "register after reset");
    end
    chk("R1", int'(busy), 0, "busy after reset");
    chk("R1", int'(irq_out), 0, "irq_out after reset");
    chk("R1", nwr, 0, "ram writes after reset");

    for (int i = 0; i < NV; i++) begin
      {k, s, d, acc, er} = VEC[i];
      clear_ram();
      wr(2'd0, k); wr(2'd1, {6'b0, s}); wr(2'd3, d);
      w0 = nwr;
      wr(2'd2, 8'h01);
      wait_idle(bc);
      @(negedge clk);
      if (!acc) begin
        // R2 wrong key: no start
        chk("R2", bc, 0, "busy cycles under wrong key");
        rd(2'd2, v); chk("R2", v, 0, "request bit under wrong key");
        chk("R2", nwr - w0, 0, "ram writes under wrong key");
      end else begin
        // R4 R5 R6 result byte
        chk(er == 0 ? "R4" : (er[0] ? "R5" : "R6"), int'(mem[d]), int'(er), "result byte");
        chk("R8", bc, (er == 0) ? 34 : 2, "busy length");
        chk(er == 0 ? "R3" : "R5", nwr - w0, (er == 0) ? 17 : 1, "ram write count");
        if (er == 0) begin
          bad_img = 0;
          for (int j = 0; j < 16; j++)
            if (mem[8'(d + 1 + j)] != img((s[1] ? 16 : 0) + j)) bad_img++;
          chk("R3", bad_img, 0, "image bytes wrong");
        end
        // R7 clear on completion
        rd(2'd1, v); chk("R7", v, 0, "select after done");
        rd(2'd2, v); chk("R7", v, 0, "request after done");
        rd(2'd0, v); chk("R7", v, int'(k), "key kept");
        rd(2'd3, v); chk("R7", v, int'(d), "dest kept");
      end
    end

    // R9 writes during a load are ignored
    clear_ram();
    wr(2'd0, 8'hA5); wr(2'd1, 8'h01); wr(2'd3, 8'h60);
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h90); wr(2'd1, 8'h03); wr(2'd0, 8'h00); wr(2'd2, 8'h01);
    wait_idle(bc);
    repeat (3) @(negedge clk);
    chk("R9", int'(busy), 0, "no restart after busy write");
    rd(2'd3, v); chk("R9", v, 8'h60, "dest unchanged");
    rd(2'd0, v); chk("R9", v, 8'hA5, "key unchanged");
    chk("R9", int'(mem[8'h60]), 0, "result at original dest");
    chk("R9", int'(mem[8'h90]), 8'hEE, "no write at ignored dest");
    chk("R9", int'(mem[8'h61]), int'(img(0)), "routine unchanged");

    // R10 interrupt held during load
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h01);
    repeat (5) @(negedge clk);
    irq_in = 1'b1;
    @(negedge clk);
    irq_in = 1'b0;
    bad_img = 0;
    while (busy) begin
      if (irq_out) bad_img++;
      @(negedge clk);
    end
    chk("R10", bad_img, 0, "irq_out while busy");
    chk("R10", int'(irq_out), 1, "held irq on first idle cycle");
    @(negedge clk);
    chk("R10", int'(irq_out), 0, "held irq one cycle only");
    irq_in = 1'b1;
    #1 chk("R10", int'(irq_out), 1, "idle passthrough");
    @(negedge clk); irq_in = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule